// File: doc/BRIEF.md
# Motion-Adaptive Recursive Noise Filter

This block lowers temporal noise in an 8-bit luminance and chrominance pixel stream. It mixes each live pixel with the co-sited pixel from one field or frame earlier, which arrives on a separate delayed-pixel input. The mix is weighted by a coefficient K, held in sixteenths. The output is `prev + K*(live - prev)`, rounded, so K = 16 passes the live pixel unchanged. One pixel is taken per clock enable. Both components use the same K.

K comes from one of two places. A test code can force it directly. Otherwise it comes from an adaptive path. That path takes a noise class (low, middle or high) and compares the luma change between the live and delayed pixels against two thresholds of that class. Pixels that change little get the strong filter coefficient of the class. Pixels that change more get the medium coefficient. Pixels that change a lot get K = 16, so moving parts of the picture do not smear.

The noise class is chosen from an external noise figure and two programmable 5-bit bounds. It can also be forced, or frozen for tape sources. It is latched only on the field-start pulse. A master enable turns the filtering off. A demonstration mode leaves the right half of each line unfiltered so the two halves can be compared.

Top module: `nr_recursive_filter`

## Requirements
- R1: While `rst` is high and at the first clock after it, `out_y`, `out_c` and `out_valid` are 0, and the latched noise class is the middle class.
- R2: `out_valid` equals `pix_en` delayed by one clock. The outputs for a pixel appear one clock after the edge at which `pix_en` was high. When `pix_en` is low, the outputs hold their values.
- R3: When filtering is active, each component outputs `prev + floor((K*(live - prev) + 8) / 16)`, clipped to 0..255. This value always lies between `live` and `prev`, and the chroma uses the same K as the luma.
- R4: With `k_force_en` = 1, K is set by `k_force_code` as follows (values in sixteenths): code 0 = 16, 1 = 12, 2 = 10, 3 = 9, 4 = 12, 5 = 8, 6 = 6, 7 = 5, 8 = 10, 9 = 6, 10 = 4, 11 = 3, 12 = 9, 13 = 5, 14 = 3, 15 = 2.
- R5: With `k_force_en` = 0, let d = |live_y - prev_y|. If d <= t_lo, K is k_strong. Else if d <= t_hi, K is k_med. Otherwise K is 16. The table per class (t_lo, t_hi, k_strong, k_med) is: class 0 = (4, 8, 10, 13), class 1 = (8, 16, 7, 11), class 2 = (12, 24, 4, 9).
- R6: At a clock where `field_start` is high, the automatic class is latched. It is class 0 if `noise_fig < thr_lo`, else class 2 if `noise_fig >= thr_hi`, else class 1.
- R7: If `cls_force_en` is 1 at the field start, `cls_force_code` sets the class: 0 gives class 0, 1 gives class 1, and 2 or 3 give class 2. This takes priority over `vcr_mode` and over the automatic choice.
- R8: If `vcr_mode` is 1 and `cls_force_en` is 0 at the field start, the class latched is class 1, whatever the noise figure and bounds.
- R9: With `nr_on` = 0, every pixel is output equal to its live input.
- R10: A pixel counter is held at 0 while `hblank` is high and counts pixels once `hblank` is low. The index used for a pixel is 0 while `hblank` is high, and otherwise the number of earlier non-blank pixels in the line. With `split_on` = 1, pixels with an index of 360 or more (half of 720) are output equal to their live input.
- R11: The latched class does not change on any clock where `field_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel enable, one pixel per high cycle |
| hblank | input | 1 | High during line blanking; holds the pixel counter at 0 |
| field_start | input | 1 | One-clock pulse at the start of a field; latches the noise class |
| live_y | input | 8 | Live luma |
| live_c | input | 8 | Live chroma |
| prev_y | input | 8 | Luma delayed by one field or frame |
| prev_c | input | 8 | Chroma delayed by one field or frame |
| nr_on | input | 1 | Filtering enable |
| split_on | input | 1 | Leave the right half of each line unfiltered |
| vcr_mode | input | 1 | Freeze the class at the middle class |
| noise_fig | input | 5 | Measured noise figure (larger means noisier) |
| thr_lo | input | 5 | Lower class bound |
| thr_hi | input | 5 | Upper class bound |
| cls_force_en | input | 1 | Force the class |
| cls_force_code | input | 2 | Forced class code |
| k_force_en | input | 1 | Force K from the code table |
| k_force_code | input | 4 | Forced K code |
| out_y | output | 8 | Filtered luma |
| out_c | output | 8 | Filtered chroma |
| out_valid | output | 1 | Output pixel valid |

## Verification
The bench drives pixel differences that sit exactly on each class's two motion thresholds and one step past them. A design that compares with `<` instead of `<=` would pick the wrong coefficient at those points. It sets the noise figure exactly equal to each class bound; an off-by-one there lands the field in a neighbouring class. It sends negative differences with odd products, where truncation toward zero gives a result one step off from the floor-based rounding. It runs a full split-screen line across pixel 359 to 360, and pauses `pix_en` mid-line, which catches a counter that advances without a pixel. It also changes the noise figure and the override codes between field starts, to catch a class that follows the inputs instead of staying latched.

// File: rtl/nr_pkg.sv
package nr_pkg;

    localparam int PIX_W   = 8;
    localparam int K_W     = 5;
    localparam int K_UNITY = 16;
    localparam int NF_W    = 5;

    typedef enum logic [1:0] {
        CLS_LOW  = 2'd0,
        CLS_MID  = 2'd1,
        CLS_HIGH = 2'd2
    } nr_class_e;

    typedef struct packed {
        logic [PIX_W-1:0] t_lo;
        logic [PIX_W-1:0] t_hi;
        logic [K_W-1:0]   k_strong;
        logic [K_W-1:0]   k_med;
    } nr_cls_par_t;

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] c;
    } nr_pix_t;

    function automatic nr_cls_par_t class_params(nr_class_e cls);
        nr_cls_par_t p;
        case (cls)
            CLS_LOW:  p = '{t_lo: 8'd4,  t_hi: 8'd8,  k_strong: 5'd10, k_med: 5'd13};
            CLS_MID:  p = '{t_lo: 8'd8,  t_hi: 8'd16, k_strong: 5'd7,  k_med: 5'd11};
            default:  p = '{t_lo: 8'd12, t_hi: 8'd24, k_strong: 5'd4,  k_med: 5'd9};
        endcase
        return p;
    endfunction

    function automatic logic [K_W-1:0] forced_k(logic [3:0] code);
        logic [K_W-1:0] k;
        case (code)
            4'd0:  k = 5'd16;
            4'd1:  k = 5'd12;
            4'd2:  k = 5'd10;
            4'd3:  k = 5'd9;
            4'd4:  k = 5'd12;
            4'd5:  k = 5'd8;
            4'd6:  k = 5'd6;
            4'd7:  k = 5'd5;
            4'd8:  k = 5'd10;
            4'd9:  k = 5'd6;
            4'd10: k = 5'd4;
            4'd11: k = 5'd3;
            4'd12: k = 5'd9;
            4'd13: k = 5'd5;
            4'd14: k = 5'd3;
            default: k = 5'd2;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/nr_class_latch.sv
module nr_class_latch
    import nr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            field_start,
    input  logic            vcr_mode,
    input  logic [NF_W-1:0] noise_fig,
    input  logic [NF_W-1:0] thr_lo,
    input  logic [NF_W-1:0] thr_hi,
    input  logic            cls_force_en,
    input  logic [1:0]      cls_force_code,
    output nr_class_e       cls_q
);

    nr_class_e cls_next;

    always_comb begin
        if (cls_force_en) begin
            case (cls_force_code)
                2'd0:    cls_next = CLS_LOW;
                2'd1:    cls_next = CLS_MID;
                default: cls_next = CLS_HIGH;
            endcase
        end else if (vcr_mode) begin
            cls_next = CLS_MID;
        end else if (noise_fig < thr_lo) begin
            cls_next = CLS_LOW;
        end else if (noise_fig >= thr_hi) begin
            cls_next = CLS_HIGH;
        end else begin
            cls_next = CLS_MID;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= CLS_MID;
        end else if (field_start) begin
            cls_q <= cls_next;
        end
    end

    AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> $stable(cls_q)); // R11

    AST_CLASS_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
        (field_start && cls_force_en && cls_force_code == 2'd0) |=> (cls_q == CLS_LOW)); // R7

    AST_VCR_MID: assert property (@(posedge clk) disable iff (rst)
        (field_start && !cls_force_en && vcr_mode) |=> (cls_q == CLS_MID)); // R8

endmodule

// File: rtl/nr_coef_sel.sv
module nr_coef_sel
    import nr_pkg::*;
(
    input  nr_class_e        cls,
    input  logic [PIX_W-1:0] live_y,
    input  logic [PIX_W-1:0] prev_y,
    input  logic             k_force_en,
    input  logic [3:0]       k_force_code,
    output logic [K_W-1:0]   k
);

    nr_cls_par_t      par;
    logic [PIX_W-1:0] absdiff;

    always_comb begin
        par     = class_params(cls);
        absdiff = (live_y >= prev_y) ? (live_y - prev_y) : (prev_y - live_y);
        if (k_force_en) begin
            k = forced_k(k_force_code);
        end else if (absdiff <= par.t_lo) begin
            k = par.k_strong;
        end else if (absdiff <= par.t_hi) begin
            k = par.k_med;
        end else begin
            k = K_W'(K_UNITY);
        end
    end

endmodule

// File: rtl/nr_blend.sv
module nr_blend
    import nr_pkg::*;
#(
    parameter int W  = PIX_W,
    parameter int KW = K_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          bypass,
    input  logic [W-1:0]  live,
    input  logic [W-1:0]  prev,
    input  logic [KW-1:0] k,
    output logic [W-1:0]  out
);

    localparam int PW   = W + KW + 2;
    localparam int FRAC = $clog2(K_UNITY);
    localparam logic signed [PW-1:0] HALF = PW'(1 << (FRAC - 1));
    localparam logic signed [PW-1:0] MAXV = PW'((1 << W) - 1);

    logic signed [W:0]    diff;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] step;
    logic signed [PW-1:0] sum;
    logic [W-1:0]         result;

    always_comb begin
        diff = $signed({1'b0, live}) - $signed({1'b0, prev});
        prod = $signed({1'b0, k}) * diff;
        step = (prod + HALF) >>> FRAC;
        sum  = $signed({{(PW-W){1'b0}}, prev}) + step;
        if (sum < 0) begin
            result = '0;
        end else if (sum > MAXV) begin
            result = '1;
        end else begin
            result = sum[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out <= '0;
        end else if (en) begin
            out <= bypass ? live : result;
        end
    end

    AST_CONVEX_RESULT: assert property (@(posedge clk) disable iff (rst)
        en |=> ((out >= $past(live) && out <= $past(prev)) ||
                (out >= $past(prev) && out <= $past(live)))); // R3

endmodule

// File: rtl/nr_line_pos.sv
module nr_line_pos #(
    parameter int ACTIVE_PIX = 720
)(
    input  logic clk,
    input  logic rst,
    input  logic pix_en,
    input  logic hblank,
    output logic right_half
);

    localparam int CW       = $clog2(ACTIVE_PIX) + 1;
    localparam int SPLIT_AT = ACTIVE_PIX / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hblank) begin
            cnt <= '0;
        end else if (pix_en && cnt != {CW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign right_half = !hblank && (cnt >= CW'(SPLIT_AT));

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hblank |=> (cnt == '0)); // R10

endmodule

// File: rtl/nr_recursive_filter.sv
module nr_recursive_filter
    import nr_pkg::*;
#(
    parameter int ACTIVE_PIX = 720
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            pix_en,
    input  logic            hblank,
    input  logic            field_start,
    input  logic [7:0]      live_y,
    input  logic [7:0]      live_c,
    input  logic [7:0]      prev_y,
    input  logic [7:0]      prev_c,
    input  logic            nr_on,
    input  logic            split_on,
    input  logic            vcr_mode,
    input  logic [4:0]      noise_fig,
    input  logic [4:0]      thr_lo,
    input  logic [4:0]      thr_hi,
    input  logic            cls_force_en,
    input  logic [1:0]      cls_force_code,
    input  logic            k_force_en,
    input  logic [3:0]      k_force_code,
    output logic [7:0]      out_y,
    output logic [7:0]      out_c,
    output logic            out_valid
);

    nr_class_e        cls;
    logic [K_W-1:0]   k;
    logic             right_half;
    logic             bypass;
    nr_pix_t          live_px;
    nr_pix_t          prev_px;
    nr_pix_t          out_px;

    assign live_px = '{y: live_y, c: live_c};
    assign prev_px = '{y: prev_y, c: prev_c};

    nr_class_latch u_class (
        .clk            (clk),
        .rst            (rst),
        .field_start    (field_start),
        .vcr_mode       (vcr_mode),
        .noise_fig      (noise_fig),
        .thr_lo         (thr_lo),
        .thr_hi         (thr_hi),
        .cls_force_en   (cls_force_en),
        .cls_force_code (cls_force_code),
        .cls_q          (cls)
    );

    nr_coef_sel u_coef (
        .cls          (cls),
        .live_y       (live_px.y),
        .prev_y       (prev_px.y),
        .k_force_en   (k_force_en),
        .k_force_code (k_force_code),
        .k            (k)
    );

    nr_line_pos #(.ACTIVE_PIX(ACTIVE_PIX)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .pix_en     (pix_en),
        .hblank     (hblank),
        .right_half (right_half)
    );

    assign bypass = !nr_on || (split_on && right_half);

    for (genvar g = 0; g < 2; g++) begin : g_comp
        logic [PIX_W-1:0] lv;
        logic [PIX_W-1:0] pv;
        logic [PIX_W-1:0] ov;
        assign lv = (g == 0) ? live_px.y : live_px.c;
        assign pv = (g == 0) ? prev_px.y : prev_px.c;
        nr_blend u_blend (
            .clk    (clk),
            .rst    (rst),
            .en     (pix_en),
            .bypass (bypass),
            .live   (lv),
            .prev   (pv),
            .k      (k),
            .out    (ov)
        );
    end

    assign out_px.y = g_comp[0].ov;
    assign out_px.c = g_comp[1].ov;
    assign out_y    = out_px.y;
    assign out_c    = out_px.c;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= pix_en;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> out_valid); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(out_y) && $stable(out_c))); // R2

    AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !nr_on) |=> (out_y == $past(live_y) && out_c == $past(live_c))); // R9

    AST_SPLIT_PASS: assert property (@(posedge clk) disable iff (rst)
        (pix_en && split_on && right_half) |=> (out_y == $past(live_y) && out_c == $past(live_c))); // R10

    AST_MOTION_PASS: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !k_force_en &&
         ((live_y > prev_y) ? (live_y - prev_y) : (prev_y - live_y)) > 8'd24)
        |=> (out_y == $past(live_y) && out_c == $past(live_c))); // R5

endmodule

// File: tb/nr_recursive_filter_bench.sv
module nr_recursive_filter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_en = 1'b0, hblank = 1'b0, field_start = 1'b0;
    logic [7:0] live_y = '0, live_c = '0, prev_y = '0, prev_c = '0;
    logic       nr_on = 1'b1, split_on = 1'b0, vcr_mode = 1'b0;
    logic [4:0] noise_fig = '0, thr_lo = 5'd4, thr_hi = 5'd16;
    logic       cls_force_en = 1'b0;
    logic [1:0] cls_force_code = '0;
    logic       k_force_en = 1'b0;
    logic [3:0] k_force_code = '0;
    logic [7:0] out_y, out_c;
    logic       out_valid;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    nr_recursive_filter u_nr_recursive_filter (
        .clk(clk), .rst(rst), .pix_en(pix_en), .hblank(hblank), .field_start(field_start),
        .live_y(live_y), .live_c(live_c), .prev_y(prev_y), .prev_c(prev_c),
        .nr_on(nr_on), .split_on(split_on), .vcr_mode(vcr_mode),
        .noise_fig(noise_fig), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .cls_force_en(cls_force_en), .cls_force_code(cls_force_code),
        .k_force_en(k_force_en), .k_force_code(k_force_code),
        .out_y(out_y), .out_c(out_c), .out_valid(out_valid)
    );

    // ---- behavioural reference model ----
    int m_cls = 1;
    int m_idx = 0;
    int e_y = 0, e_c = 0, e_v = 0;

    function automatic int ktab(int code);
        int t[16] = '{16, 12, 10, 9, 12, 8, 6, 5, 10, 6, 4, 3, 9, 5, 3, 2};
        return t[code];
    endfunction

    function automatic int mix(int lv, int pv, int k);
        int num = k * (lv - pv) + 8;
        int q;
        int r;
        if (num >= 0) q = num / 16;
        else          q = -((-num + 15) / 16);
        r = pv + q;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    function automatic int pick_k(int cls, int ly, int py);
        int tlo[3] = '{4, 8, 12};
        int thi[3] = '{8, 16, 24};
        int ks[3]  = '{10, 7, 4};
        int km[3]  = '{13, 11, 9};
        int ad = (ly > py) ? ly - py : py - ly;
        if (k_force_en) return ktab(int'(k_force_code));
        if (ad <= tlo[cls]) return ks[cls];
        if (ad <= thi[cls]) return km[cls];
        return 16;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cls = 1; m_idx = 0; e_y = 0; e_c = 0; e_v = 0;
        end else begin
            int idx;
            int k;
            idx = hblank ? 0 : m_idx;
            e_v = int'(pix_en);
            if (pix_en) begin
                if (!nr_on || (split_on && idx >= 360)) begin
                    e_y = int'(live_y); e_c = int'(live_c);
                end else begin
                    k = pick_k(m_cls, int'(live_y), int'(prev_y));
                    e_y = mix(int'(live_y), int'(prev_y), k);
                    e_c = mix(int'(live_c), int'(prev_c), k);
                end
            end
            if (hblank) m_idx = 0;
            else if (pix_en && m_idx < 2047) m_idx = m_idx + 1;
            if (field_start) begin
                if (cls_force_en)                m_cls = (cls_force_code == 0) ? 0 : (cls_force_code == 1) ? 1 : 2;
                else if (vcr_mode)               m_cls = 1;
                else if (noise_fig < thr_lo)     m_cls = 0;
                else if (noise_fig >= thr_hi)    m_cls = 2;
                else                             m_cls = 1;
            end
        end
    end

    // ---- per-clock comparison, away from the active edge ----
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(out_y) != e_y || int'(out_c) != e_c || int'(out_valid) != e_v) begin
                errors++;
                $display("FAIL %s: y=%0d c=%0d v=%0d expected y=%0d c=%0d v=%0d",
                         tag, out_y, out_c, out_valid, e_y, e_c, e_v);
            end
        end
    end

    task automatic px(input int ly, input int lc, input int py, input int pc);
        @(negedge clk);
        pix_en = 1'b1; field_start = 1'b0;
        live_y = 8'(ly); live_c = 8'(lc); prev_y = 8'(py); prev_c = 8'(pc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_en = 1'b0; field_start = 1'b0;
        end
    endtask

    task automatic new_field;
        @(negedge clk);
        pix_en = 1'b0; field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
    endtask

    task automatic sweep_diffs(input int base);
        int ds[12] = '{0, 3, 4, 5, 8, 9, 12, 13, 16, 17, 24, 25};
        foreach (ds[i]) begin
            px(base + ds[i], 128 - ds[i], base, 128 + 7);
            px(base, 128 + 5, base + ds[i], 121);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen during reset
        checks++;
        if (out_y !== 8'd0 || out_c !== 8'd0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: y=%0d c=%0d v=%0d expected 0 0 0", out_y, out_c, out_valid);
        end
        rst = 1'b0;
        tag = "R1";
        idle(2);

        // R2: latency, hold while pix_en low
        tag = "R2";
        px(200, 50, 100, 90);
        idle(3);
        px(10, 240, 30, 200);
        px(77, 77, 70, 80);
        idle(1);

        // R9: filtering off
        tag = "R9";
        nr_on = 1'b0;
        for (int i = 0; i < 20; i++) px($urandom_range(0, 255), $urandom_range(0, 255),
                                        $urandom_range(0, 255), $urandom_range(0, 255));
        nr_on = 1'b1;

        // R4 / R3: every forced code, positive and negative differences
        tag = "R4";
        k_force_en = 1'b1;
        for (int c = 0; c < 16; c++) begin
            k_force_code = 4'(c);
            px(255, 0, 0, 255);
            px(0, 255, 255, 0);
            px(101, 33, 98, 40);
            px(90, 17, 97, 12);
        end
        tag = "R3";
        for (int i = 0; i < 40; i++) begin
            k_force_code = 4'($urandom_range(0, 15));
            px($urandom_range(0, 255), $urandom_range(0, 255),
               $urandom_range(0, 255), $urandom_range(0, 255));
        end
        k_force_en = 1'b0;

        // R7 / R5: forced classes, differences on each threshold
        tag = "R7";
        cls_force_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            cls_force_code = 2'(c);
            new_field();
            tag = "R5";
            sweep_diffs(60);
            tag = "R7";
        end
        vcr_mode = 1'b1;
        cls_force_code = 2'd0;
        new_field();
        sweep_diffs(150);
        cls_force_en = 1'b0;

        // R8: tape mode holds the middle class
        tag = "R8";
        noise_fig = 5'd0; thr_lo = 5'd4; thr_hi = 5'd16;
        new_field();
        sweep_diffs(100);
        vcr_mode = 1'b0;

        // R6: automatic classification, bounds included
        tag = "R6";
        begin
            int nfs[6] = '{0, 3, 4, 15, 16, 31};
            foreach (nfs[i]) begin
                noise_fig = 5'(nfs[i]);
                new_field();
                sweep_diffs(40);
            end
        end
        thr_lo = 5'd20; thr_hi = 5'd10; noise_fig = 5'd15;
        new_field();
        sweep_diffs(80);
        thr_lo = 5'd4; thr_hi = 5'd16;

        // R11: inputs change with no field start
        tag = "R11";
        noise_fig = 5'd31; cls_force_en = 1'b1; cls_force_code = 2'd0; vcr_mode = 1'b1;
        sweep_diffs(120);
        cls_force_en = 1'b0; vcr_mode = 1'b0;

        // R10: split screen over a full line with gaps
        tag = "R10";
        split_on = 1'b1;
        k_force_en = 1'b1; k_force_code = 4'd15;
        for (int ln = 0; ln < 2; ln++) begin
            @(negedge clk); hblank = 1'b1; pix_en = 1'b1;
            live_y = 8'd200; prev_y = 8'd10; live_c = 8'd5; prev_c = 8'd250;
            @(negedge clk); hblank = 1'b1; pix_en = 1'b0;
            @(negedge clk); hblank = 1'b0;
            for (int p = 0; p < 720; p++) begin
                px((p * 7) & 255, (p * 3 + 11) & 255, (p * 5 + 40) & 255, 255 - (p & 255));
                if (p == 358 || p == 500) idle(2);
            end
        end
        split_on = 1'b0; k_force_en = 1'b0;
        idle(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule